// File: doc/BRIEF.md
# Link Port Word Serializer

This block is the sending half of a point-to-point link port. A producer offers one word at a time through a single-word holding interface. The serializer takes the word and sends it over a narrow link as a series of nibble-sized chunks. A link clock qualifier marks each core cycle that carries data. Words are either 32 or 48 bits long.

In normal mode the link moves one nibble per core cycle on lane A. In double-rate mode it moves two nibbles per core cycle, on lane A and then lane B, which is an effective byte per cycle. A 32-bit word therefore takes 8 or 4 cycles, and a 48-bit word takes 12 or 6 cycles.

While the final chunk of a word is on the link, the port raises a next-word request. If a word is waiting in that cycle, it is taken and its first chunk follows with no idle cycle. If no word is waiting, the link goes quiet.

Top module: `lnk_word_ser`

## Requirements
- R1: After reset, `lk_clk`, `busy` and `nxt_req` are low and both data lanes are zero.
- R2: `wd_long` = 1 selects a 48-bit word and 0 selects a 32-bit word, in which case bits 47:32 of `wd_data` are ignored. `wd_long` and `wd_dual` are sampled only in the cycle a word is taken, so changing them while a word is in flight has no effect on that word.
- R3: In normal mode (`wd_dual` = 0) each busy cycle carries one nibble on `lk_lane_a` and `lk_lane_b` is driven as zero. A 32-bit word takes 8 cycles and a 48-bit word takes 12 cycles.
- R4: In double-rate mode (`wd_dual` = 1) each busy cycle carries two nibbles, the earlier one on `lk_lane_a` and the next one on `lk_lane_b`. A 32-bit word takes 4 cycles and a 48-bit word takes 6 cycles.
- R5: Nibbles leave least significant first: nibble k of the word is bits 4k+3:4k, sent in increasing k.
- R6: `nxt_req` is high exactly in the cycle that the final chunk of a word is on the lanes, and in no other cycle.
- R7: `wd_take` is high only when `wd_valid` is high and the port is either idle or driving a final chunk. The word present in that cycle is loaded at the next rising clock edge.
- R8: When a word is taken during a final chunk, the next cycle carries the first chunk of the new word and `lk_clk` stays high with no gap.
- R9: When a word completes with no word waiting, `lk_clk` and `busy` drop low in the next cycle, and both lanes hold their last values for as long as the port stays idle.
- R10: `busy` and `lk_clk` are high from the cycle after a take through the cycle of that word's final chunk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wd_valid | input | 1 | Holding buffer has a word for the port |
| wd_data | input | 48 | Word to send; bits 47:32 are unused for 32-bit words |
| wd_long | input | 1 | 1 = 48-bit word, 0 = 32-bit word; sampled on take |
| wd_dual | input | 1 | 1 = double-rate (two nibbles per cycle); sampled on take |
| wd_take | output | 1 | The offered word is consumed at the next edge |
| nxt_req | output | 1 | Final chunk is on the link; next word wanted |
| lk_clk | output | 1 | Link clock qualifier, high in each cycle carrying data |
| lk_lane_a | output | 4 | First nibble slot of the current cycle |
| lk_lane_b | output | 4 | Second nibble slot (double-rate only, else zero) |
| busy | output | 1 | A word is in flight |

## Verification
The bench sweeps all four size and mode combinations, with idle gaps of zero, one and three cycles between words. It rebuilds each word from the lanes and compares it with the expected value. A chunk counter that is off by one would truncate words or stretch them into the next, and nibbles emitted in the wrong order would corrupt the rebuilt value. Words follow each other back to back with the format flipped while each word is in flight, so sampling the mode live rather than at take time shows up as a wrong chunk count. The bench also checks the link idle cycles and request timing: a missing gapless reload would put an idle cycle into a continuous stream, and a link that does not hold its lanes or lower its clock when starved would fail the idle checks.

// File: rtl/lws_pkg.sv
package lws_pkg;

   // Format of one word as latched when it is taken from the holding buffer
   typedef struct packed {
      logic long_w;   // 1: long word, 0: short word
      logic dual;     // 1: two nibble slots per core cycle
   } lws_fmt_t;

endpackage

// File: rtl/lws_beat_plan.sv
// Computes index of the final beat of a word for a given format.
module lws_beat_plan
   import lws_pkg::*;
#(
   parameter int LANE_W  = 4,
   parameter int SHORT_W = 32,
   parameter int LONG_W  = 48,
   parameter bit DUAL_EN = 1'b1,
   parameter int CNT_W   = 4
) (
   input  lws_fmt_t         fmt,
   output logic [CNT_W-1:0] last_idx
);

   localparam int BEATS_SN = SHORT_W / LANE_W;
   localparam int BEATS_LN = LONG_W / LANE_W;
   localparam int BEATS_SD = SHORT_W / (2 * LANE_W);
   localparam int BEATS_LD = LONG_W / (2 * LANE_W);

   generate
      if (DUAL_EN) begin : g_dual
         always_comb begin
            unique case ({fmt.long_w, fmt.dual})
               2'b00:   last_idx = CNT_W'(BEATS_SN - 1);
               2'b01:   last_idx = CNT_W'(BEATS_SD - 1);
               2'b10:   last_idx = CNT_W'(BEATS_LN - 1);
               default: last_idx = CNT_W'(BEATS_LD - 1);
            endcase
         end
      end else begin : g_single
         logic unused_dual;
         assign unused_dual = fmt.dual;
         assign last_idx = fmt.long_w ? CNT_W'(BEATS_LN - 1) : CNT_W'(BEATS_SN - 1);
      end
   endgenerate

endmodule

// File: rtl/lws_sequencer.sv
// Beat counter and take/advance control for one word in flight.
module lws_sequencer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wd_valid,
   input  logic             dual_in,
   input  logic [CNT_W-1:0] last_in,
   output logic             take,
   output logic             adv,
   output logic             active,
   output logic             final_beat,
   output logic             dual_q
);

   logic [CNT_W-1:0] idx_q;
   logic [CNT_W-1:0] last_q;

   assign final_beat = active && (idx_q == last_q);
   assign take       = wd_valid && (!active || final_beat);
   assign adv        = active && !final_beat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx_q  <= '0;
         last_q <= '0;
         dual_q <= 1'b0;
      end else if (take) begin
         active <= 1'b1;
         idx_q  <= '0;
         last_q <= last_in;
         dual_q <= dual_in;
      end else if (final_beat) begin
         active <= 1'b0;
      end else if (active) begin
         idx_q  <= idx_q + 1'b1;
      end
   end

endmodule

// File: rtl/lws_shifter.sv
// Holds the untransmitted part of the word and drives the nibble lanes.
module lws_shifter #(
   parameter int LANE_W  = 4,
   parameter int LONG_W  = 48,
   parameter bit DUAL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              adv,
   input  logic              dual_in,
   input  logic              dual_q,
   input  logic [LONG_W-1:0] data_in,
   output logic [LANE_W-1:0] lane_a,
   output logic [LANE_W-1:0] lane_b
);

   localparam int PAIR_W = 2 * LANE_W;

   logic [LONG_W-1:0] rest_q;

   generate
      if (DUAL_EN) begin : g_dual
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lane_a <= '0;
               lane_b <= '0;
               rest_q <= '0;
            end else if (load) begin
               lane_a <= data_in[LANE_W-1:0];
               if (dual_in) begin
                  lane_b <= data_in[PAIR_W-1:LANE_W];
                  rest_q <= data_in >> PAIR_W;
               end else begin
                  lane_b <= '0;
                  rest_q <= data_in >> LANE_W;
               end
            end else if (adv) begin
               lane_a <= rest_q[LANE_W-1:0];
               if (dual_q) begin
                  lane_b <= rest_q[PAIR_W-1:LANE_W];
                  rest_q <= rest_q >> PAIR_W;
               end else begin
                  lane_b <= '0;
                  rest_q <= rest_q >> LANE_W;
               end
            end
         end
      end else begin : g_single
         logic unused_mode;
         assign unused_mode = dual_in ^ dual_q;
         assign lane_b = '0;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lane_a <= '0;
               rest_q <= '0;
            end else if (load) begin
               lane_a <= data_in[LANE_W-1:0];
               rest_q <= data_in >> LANE_W;
            end else if (adv) begin
               lane_a <= rest_q[LANE_W-1:0];
               rest_q <= rest_q >> LANE_W;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/lnk_word_ser.sv
// Link port word serializer: top level.
module lnk_word_ser
   import lws_pkg::*;
#(
   parameter int LANE_W  = 4,
   parameter int SHORT_W = 32,
   parameter int LONG_W  = 48,
   parameter bit DUAL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wd_valid,
   input  logic [LONG_W-1:0] wd_data,
   input  logic              wd_long,
   input  logic              wd_dual,
   output logic              wd_take,
   output logic              nxt_req,
   output logic              lk_clk,
   output logic [LANE_W-1:0] lk_lane_a,
   output logic [LANE_W-1:0] lk_lane_b,
   output logic              busy
);

   localparam int MAX_BEATS = LONG_W / LANE_W;
   localparam int CNT_W     = $clog2(MAX_BEATS);

   generate
      if (LANE_W < 1) begin : g_bad_lane
         $error("LANE_W must be positive");
      end
      if (SHORT_W >= LONG_W) begin : g_bad_order
         $error("SHORT_W must be below LONG_W");
      end
      if ((SHORT_W % (2 * LANE_W)) != 0 || (LONG_W % (2 * LANE_W)) != 0) begin : g_bad_div
         $error("word widths must be whole multiples of two lanes");
      end
   endgenerate

   lws_fmt_t         fmt_in;
   logic [CNT_W-1:0] last_in;
   logic             adv;
   logic             active;
   logic             final_beat;
   logic             dual_q;
   logic             clk_q;

   assign fmt_in.long_w = wd_long;
   assign fmt_in.dual   = wd_dual & DUAL_EN;

   lws_beat_plan #(
      .LANE_W (LANE_W),
      .SHORT_W(SHORT_W),
      .LONG_W (LONG_W),
      .DUAL_EN(DUAL_EN),
      .CNT_W  (CNT_W)
   ) plan_i (
      .fmt     (fmt_in),
      .last_idx(last_in)
   );

   lws_sequencer #(
      .CNT_W(CNT_W)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wd_valid  (wd_valid),
      .dual_in   (fmt_in.dual),
      .last_in   (last_in),
      .take      (wd_take),
      .adv       (adv),
      .active    (active),
      .final_beat(final_beat),
      .dual_q    (dual_q)
   );

   lws_shifter #(
      .LANE_W (LANE_W),
      .LONG_W (LONG_W),
      .DUAL_EN(DUAL_EN)
   ) shf_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (wd_take),
      .adv    (adv),
      .dual_in(fmt_in.dual),
      .dual_q (dual_q),
      .data_in(wd_data),
      .lane_a (lk_lane_a),
      .lane_b (lk_lane_b)
   );

   // Link clock qualifier is its own register: high for every cycle a chunk is on the lanes
   always_ff @(posedge clk) begin
      if (!rst_n) clk_q <= 1'b0;
      else        clk_q <= wd_take || adv;
   end

   assign lk_clk  = clk_q;
   assign busy    = active;
   assign nxt_req = final_beat;

endmodule

// File: rtl/lws_chk.sv
// Protocol checker for lnk_word_ser, attached by bind.
module lws_chk #(
   parameter int LANE_W  = 4,
   parameter int SHORT_W = 32,
   parameter int LONG_W  = 48,
   parameter bit DUAL_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wd_valid,
   input logic              wd_long,
   input logic              wd_dual,
   input logic              wd_take,
   input logic              nxt_req,
   input logic              lk_clk,
   input logic [LANE_W-1:0] lk_lane_a,
   input logic [LANE_W-1:0] lk_lane_b,
   input logic              busy
);

   logic [7:0] cnt_q;
   logic [7:0] exp_last_q;
   logic       dual_seen_q;
   logic [7:0] exp_last_d;
   logic       dual_eff;

   assign dual_eff   = wd_dual && DUAL_EN;
   assign exp_last_d = 8'((wd_long ? LONG_W : SHORT_W) / (dual_eff ? 2 * LANE_W : LANE_W) - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         exp_last_q  <= '0;
         dual_seen_q <= 1'b0;
      end else if (wd_take) begin
         cnt_q       <= '0;
         exp_last_q  <= exp_last_d;
         dual_seen_q <= dual_eff;
      end else if (busy) begin
         cnt_q       <= cnt_q + 8'd1;
      end
   end

   a_r10_clk_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
      lk_clk == busy);

   a_r6_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      nxt_req |-> busy);

   a_r6_req_on_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
      nxt_req |-> (cnt_q == exp_last_q));

   a_r10_busy_until_last: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !nxt_req) |=> busy);

   a_r7_take_gated: assert property (@(posedge clk) disable iff (!rst_n)
      wd_take |-> (wd_valid && (!busy || nxt_req)));

   a_r8_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (nxt_req && wd_valid) |=> (lk_clk && busy));

   a_r9_drop_when_starved: assert property (@(posedge clk) disable iff (!rst_n)
      (nxt_req && !wd_valid) |=> (!busy && !lk_clk));

   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !wd_take) |=> ($stable(lk_lane_a) && $stable(lk_lane_b)));

   a_r3_lane_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !dual_seen_q) |-> (lk_lane_b == '0));

endmodule

bind lnk_word_ser lws_chk #(
   .LANE_W (LANE_W),
   .SHORT_W(SHORT_W),
   .LONG_W (LONG_W),
   .DUAL_EN(DUAL_EN)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .wd_valid (wd_valid),
   .wd_long  (wd_long),
   .wd_dual  (wd_dual),
   .wd_take  (wd_take),
   .nxt_req  (nxt_req),
   .lk_clk   (lk_clk),
   .lk_lane_a(lk_lane_a),
   .lk_lane_b(lk_lane_b),
   .busy     (busy)
);

// File: tb/lnk_word_ser_tb_top.sv
module lnk_word_ser_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wd_valid = 1'b0;
   logic [47:0] wd_data = '0;
   logic        wd_long = 1'b0;
   logic        wd_dual = 1'b0;
   logic        wd_take;
   logic        nxt_req;
   logic        lk_clk;
   logic [3:0]  lk_lane_a;
   logic [3:0]  lk_lane_b;
   logic        busy;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   lnk_word_ser dut_i (
      .clk(clk), .rst_n(rst_n), .wd_valid(wd_valid), .wd_data(wd_data),
      .wd_long(wd_long), .wd_dual(wd_dual), .wd_take(wd_take), .nxt_req(nxt_req),
      .lk_clk(lk_clk), .lk_lane_a(lk_lane_a), .lk_lane_b(lk_lane_b), .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // Expected word queue
   logic [47:0] q_data [0:255];
   bit          q_long [0:255];
   bit          q_dual [0:255];
   int          q_head = 0;
   int          q_tail = 0;

   // Driver: offer a word and hold it until taken
   task automatic push(input logic [47:0] d, input bit lng, input bit dul);
      wd_data  = d;
      wd_long  = lng;
      wd_dual  = dul;
      wd_valid = 1'b1;
      #1;
      while (!wd_take) begin
         @(negedge clk);
         #1;
      end
      q_data[q_tail[7:0]] = lng ? d : {16'h0, d[31:0]};
      q_long[q_tail[7:0]] = lng;
      q_dual[q_tail[7:0]] = dul;
      q_tail++;
      @(negedge clk);
      // flip format inputs while the word is in flight (R2: must be ignored)
      wd_long = ~lng;
      wd_dual = ~dul;
   endtask

   task automatic idle(input int n);
      wd_valid = 1'b0;
      wd_long  = ~wd_long;
      wd_dual  = ~wd_dual;
      repeat (n) @(negedge clk);
   endtask

   // Monitor state
   logic [63:0] acc = '0;
   int          nib = 0;
   int          beats = 0;
   bit          req_bad = 1'b0;
   bit          laneb_bad = 1'b0;
   bit          prev_req = 1'b0;
   bit          prev_valid = 1'b0;
   logic [3:0]  prev_a = '0;
   logic [3:0]  prev_b = '0;

   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         if (prev_req && prev_valid)
            chk(lk_clk == 1'b1, "R8 no gap after reload", {63'h0, lk_clk}, 64'h1);
         if (prev_req && !prev_valid)
            chk(lk_clk == 1'b0 && busy == 1'b0, "R9 drop when starved", {62'h0, lk_clk, busy}, 64'h0);
         if (wd_take)
            chk(!busy || nxt_req, "R7 take only idle or final", {62'h0, busy, nxt_req}, 64'h1);
         if (lk_clk) begin
            chk(busy == 1'b1, "R10 busy with link clock", {63'h0, busy}, 64'h1);
            if (q_head == q_tail) begin
               chk(1'b0, "R10 chunk with no word taken", 64'h1, 64'h0);
            end else begin
               automatic int  idx   = q_head;
               automatic bit  lng   = q_long[idx[7:0]];
               automatic bit  dul   = q_dual[idx[7:0]];
               automatic int  total = lng ? 12 : 8;
               automatic bit  fin;
               if (nib < 16) acc[nib*4 +: 4] = lk_lane_a;
               nib++;
               if (dul) begin
                  if (nib < 16) acc[nib*4 +: 4] = lk_lane_b;
                  nib++;
               end else if (lk_lane_b != 4'h0) begin
                  laneb_bad = 1'b1;
               end
               beats++;
               fin = (nib >= total);
               if (nxt_req != fin) req_bad = 1'b1;
               if (fin) begin
                  chk(acc == {16'h0, q_data[idx[7:0]]}, "R5 word rebuilt LS nibble first (R2 size)",
                      acc, {16'h0, q_data[idx[7:0]]});
                  if (dul)
                     chk(beats == total / 2, "R4 double-rate beat count", 64'(beats), 64'(total / 2));
                  else
                     chk(beats == total, "R3 normal beat count", 64'(beats), 64'(total));
                  chk(!req_bad, "R6 request only on final chunk", {63'h0, req_bad}, 64'h0);
                  if (!dul) chk(!laneb_bad, "R3 lane B zero in normal mode", {63'h0, laneb_bad}, 64'h0);
                  acc = '0; nib = 0; beats = 0; req_bad = 1'b0; laneb_bad = 1'b0;
                  q_head++;
               end
            end
         end else begin
            chk(!busy && !nxt_req, "R9 idle flags low", {62'h0, busy, nxt_req}, 64'h0);
            chk(lk_lane_a == prev_a && lk_lane_b == prev_b, "R9 lanes hold while idle",
                {56'h0, lk_lane_a, lk_lane_b}, {56'h0, prev_a, prev_b});
         end
         prev_req   = nxt_req;
         prev_valid = wd_valid;
         prev_a     = lk_lane_a;
         prev_b     = lk_lane_b;
      end
   end

   // Watchdog
   initial begin
      #(8 * 200000);
      if (!done) begin
         chk(1'b0, "watchdog expired", 64'h0, 64'h1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   logic [31:0] seed = 32'h1234_5678;
   function automatic logic [47:0] next_word();
      logic [31:0] a;
      logic [31:0] b;
      seed = seed * 32'h0019_660D + 32'h3C6E_F35F;
      a = seed;
      seed = seed * 32'h0019_660D + 32'h3C6E_F35F;
      b = seed;
      return {a[31:16], b};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state
      chk(lk_clk == 1'b0 && busy == 1'b0 && nxt_req == 1'b0, "R1 reset flags low",
          {61'h0, lk_clk, busy, nxt_req}, 64'h0);
      chk(lk_lane_a == 4'h0 && lk_lane_b == 4'h0, "R1 reset lanes zero",
          {56'h0, lk_lane_a, lk_lane_b}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // Fixed patterns for nibble order (R5) in every format
      push(48'hFEDC_BA98_7654, 1'b1, 1'b0); idle(2);
      push(48'hFEDC_BA98_7654, 1'b1, 1'b1); idle(2);
      push(48'hAAAA_0123_4567, 1'b0, 1'b0); idle(2);  // R2: upper bits ignored
      push(48'h5555_89AB_CDEF, 1'b0, 1'b1); idle(2);

      // Sweep: format x gap, three words per burst
      for (int cfg = 0; cfg < 4; cfg++) begin
         for (int g = 0; g < 3; g++) begin
            for (int w = 0; w < 3; w++) push(next_word(), cfg[1], cfg[0]);
            idle(g == 0 ? 1 : (g == 1 ? 2 : 4));
         end
      end

      // Gapless stream with format changing on every word (R8, R2)
      for (int w = 0; w < 16; w++) push(next_word(), w[0] ^ w[2], w[1]);
      idle(3);

      // Word offered in the middle of a word waits for final chunk (R7)
      push(next_word(), 1'b1, 1'b0);
      push(next_word(), 1'b0, 1'b1);
      idle(20);

      chk(q_head == q_tail, "R10 every taken word appeared on link", 64'(q_head), 64'(q_tail));
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule